// File: doc/BRIEF.md
# Rotated Immediate Constant Encoder

This block decides how a 32-bit constant can be placed into a 12-bit immediate field. The field holds a 4-bit rotation code and an 8-bit pattern. The constant equals the pattern rotated right by twice the code. Because the rotation is always twice the code, only even rotations of the word can be reached.

When the constant cannot be encoded directly but its bitwise complement can, the block reports that an inverted move is needed and returns the field for the complement. When neither form fits, it reports that the constant must be loaded from a literal pool.

A single-cycle `start` pulse captures the constant. The block then tests one rotation code per clock:

- First it tests the constant itself, with codes 0 to 15.
- Then it tests the complement, with codes 0 to 15.
- It stops at the first hit, so the smallest code wins within each pass.

The block then raises `done` for one clock, together with the outcome and the field.

Top module: `rot_imm_encoder`

## Requirements
- R1: `field[11:8]` is the rotation code and `field[7:0]` is the pattern. Rotating the zero-extended pattern right by 2×code gives the constant for a direct outcome, or its complement for an inverted outcome.
- R2: Any constant from 0 to 255 gives outcome 00 (direct) with field equal to the constant. The constant 0 gives field 0x000.
- R3: Every single-bit constant (a power of two) gives outcome 00.
- R4: Among the passing codes, the smallest one is reported. 0x00000204 gives field 0xF81, and 0x10000008 gives field 0x281, both with outcome 00.
- R5: 0x00000101 and 0x00000102 are never reported as direct. Both give outcome 10 (pool).
- R6: If the constant fails every code but its complement passes, the outcome is 01 (inverted). 0xEFFFFFF7 gives 0x281, 0xFFFFF00F gives 0xEFF, and 0xFFFFFFFF gives 0x000.
- R7: If neither the constant nor its complement passes, the outcome is 10 and the field is 0x000. 0xFF0000FF and 0x007F9000 take this path.
- R8: The search begins at the clock edge that samples `start`, and `busy` is high while it runs. `done` is high for exactly one cycle, and `busy` is low during that cycle. The `done` cycle comes after the following number of later edges:
  - code+1 for a direct hit;
  - 17+code for an inverted hit;
  - 32 for a pool result.
- R9: A `start` that arrives while `busy` is high is ignored. The running search and its result are unaffected.
- R10: `outcome` and `field` change only on the edge that raises `done`. They hold their values at all other times.
- R11: After reset the block shows `busy`=0, `done`=0, `outcome`=00 and `field`=0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that captures `value` when the block is idle |
| value | input | 32 | Constant to encode |
| busy | output | 1 | High while the search is running |
| done | output | 1 | One-cycle pulse when a result is ready |
| outcome | output | 2 | 00 direct, 01 inverted, 10 pool load |
| field | output | 12 | Rotation code (bits 11:8) and pattern (bits 7:0) |

## Verification
The captured constant, the current code and the pass bit (direct or complement) all decide when `done` rises. An error in any of them shows up at the ports as a `done` pulse that is off by at least one cycle, or as a wrong code or outcome in that same cycle. A constant altered by a start that arrived while busy is exposed by a shorter latency or a different field. A leak of the field registers shows up as a change during the busy window. For both of these, the bench compares the ports against its model on every clock.

// File: rtl/rot_imm_pkg.sv
package rot_imm_pkg;
    localparam int DATA_W = 32;
    localparam int PAT_W  = 8;
    localparam int CODE_W = 4;
    localparam int FLD_W  = CODE_W + PAT_W;

    typedef enum logic [1:0] {
        RES_DIRECT = 2'b00,
        RES_INVERT = 2'b01,
        RES_POOL   = 2'b10
    } res_e;

    typedef struct packed {
        logic              busy;
        logic              inv_pass;
        logic [CODE_W-1:0] code;
        logic [DATA_W-1:0] word;
        logic              done;
        res_e              res;
        logic [FLD_W-1:0]  fld;
    } enc_state_t;
endpackage

// File: rtl/rot_imm_fit.sv
module rot_imm_fit #(
    parameter int DATA_W = 32,
    parameter int PAT_W  = 8,
    parameter int CODE_W = 4
) (
    input  logic [DATA_W-1:0] word,
    input  logic [CODE_W-1:0] code,
    output logic              fits,
    output logic [PAT_W-1:0]  pattern
);
    localparam int NCODE = 1 << CODE_W;
    localparam int STEP  = DATA_W / NCODE;

    logic [2*DATA_W-1:0] dbl_d;
    logic [DATA_W-1:0]   rot_d;

    always_comb begin
        dbl_d   = {word, word} << (int'(code) * STEP);
        rot_d   = dbl_d[2*DATA_W-1:DATA_W];
        fits    = ~|rot_d[DATA_W-1:PAT_W];
        pattern = rot_d[PAT_W-1:0];
    end
endmodule

// File: rtl/rot_imm_encoder.sv
module rot_imm_encoder
    import rot_imm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] value,
    output logic              busy,
    output logic              done,
    output logic [1:0]        outcome,
    output logic [FLD_W-1:0]  field
);
    localparam int NCODE = 1 << CODE_W;
    localparam int STEP  = DATA_W / NCODE;
    localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NCODE - 1);

    enc_state_t st_q, st_d;

    logic [1:0]       fit_ok;
    logic [PAT_W-1:0] fit_pat [2];

    for (genvar g = 0; g < 2; g++) begin : g_fit
        logic [DATA_W-1:0] src;
        assign src = (g == 1) ? ~st_q.word : st_q.word;
        rot_imm_fit #(.DATA_W(DATA_W), .PAT_W(PAT_W), .CODE_W(CODE_W)) u_fit (
            .word    (src),
            .code    (st_q.code),
            .fits    (fit_ok[g]),
            .pattern (fit_pat[g])
        );
    end

    logic             hit_d;
    logic [PAT_W-1:0] pat_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        hit_d     = st_q.inv_pass ? fit_ok[1]  : fit_ok[0];
        pat_d     = st_q.inv_pass ? fit_pat[1] : fit_pat[0];
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy     = 1'b1;
                st_d.inv_pass = 1'b0;
                st_d.code     = '0;
                st_d.word     = value;
            end
        end else if (hit_d) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.res  = st_q.inv_pass ? RES_INVERT : RES_DIRECT;
            st_d.fld  = {st_q.code, pat_d};
        end else if (st_q.code == LAST_CODE) begin
            if (st_q.inv_pass) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.res  = RES_POOL;
                st_d.fld  = '0;
            end else begin
                st_d.inv_pass = 1'b1;
                st_d.code     = '0;
            end
        end else begin
            st_d.code = st_q.code + CODE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, inv_pass: 1'b0, code: '0, word: '0,
                      done: 1'b0, res: RES_DIRECT, fld: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign outcome = st_q.res;
    assign field   = st_q.fld;

    // Checker: rebuild the word from the reported field by rotating right
    logic [2*DATA_W-1:0] rebuild_dbl;
    logic [DATA_W-1:0]   rebuilt;
    logic [DATA_W-1:0]   pat_ext;
    always_comb begin
        pat_ext     = {{(DATA_W-PAT_W){1'b0}}, field[PAT_W-1:0]};
        rebuild_dbl = {pat_ext, pat_ext} >> (int'(field[FLD_W-1:PAT_W]) * STEP);
        rebuilt     = rebuild_dbl[DATA_W-1:0];
    end

    // R1
    field_rebuild_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && outcome != RES_POOL) |->
            (rebuilt == ((outcome == RES_INVERT) ? ~st_q.word : st_q.word)));
    // R7
    pool_zero_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && outcome == RES_POOL) |-> (field == '0));
    // R8
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9
    word_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.word));
    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_d.done |=> ($stable(field) && $stable(outcome)));
endmodule

// File: tb/tb_rot_imm_encoder.sv
`timescale 1ns/1ps
module tb_rot_imm_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] din = '0;
    logic        busy, done;
    logic [1:0]  outcome;
    logic [11:0] field;

    int n_cmp = 0;
    int n_bad = 0;
    logic [1:0]  prev_oc  = 2'b00;
    logic [11:0] prev_fld = 12'h000;

    always #2.5 clk = ~clk;

    rot_imm_encoder dut (
        .clk(clk), .rst_n(rst_n), .start(start), .value(din),
        .busy(busy), .done(done), .outcome(outcome), .field(field)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural model: bit-by-bit rotation, direct pass then complement pass
    function automatic void model(input logic [31:0] v, output logic [1:0] oc,
                                  output logic [11:0] fld, output int lat);
        logic [31:0] t;
        logic [31:0] r;
        oc = 2'b10; fld = 12'h000; lat = 32;
        for (int pass = 1; pass >= 0; pass--) begin
            t = (pass == 1) ? ~v : v;
            for (int c = 15; c >= 0; c--) begin
                for (int i = 0; i < 32; i++) r[(i + 2*c) % 32] = t[i];
                if (r < 32'd256) begin
                    oc  = (pass == 1) ? 2'b01 : 2'b00;
                    fld = {c[3:0], r[7:0]};
                    lat = pass*16 + c + 1;
                end
            end
        end
    endfunction

    task automatic run(input logic [31:0] v, input string req, input bit poke);
        logic [1:0]  eoc;
        logic [11:0] efld;
        int          lat;
        model(v, eoc, efld, lat);
        @(negedge clk); start = 1'b1; din = v;
        @(negedge clk); start = 1'b0; din = ~v;
        check(busy == 1'b1, "R8", "busy after start", 32'(busy), 32'd1);
        for (int n = 1; n <= lat + 1; n++) begin
            @(negedge clk);
            start = 1'b0;
            check(busy == (n < lat), "R8", "busy", 32'(busy), 32'(n < lat));
            check(done == (n == lat), "R8", "done timing", 32'(done), 32'(n == lat));
            if (n < lat) begin
                check(field == prev_fld && outcome == prev_oc, "R10", "hold during search",
                      {18'd0, outcome, field}, {18'd0, prev_oc, prev_fld});
            end else begin
                check(outcome == eoc, req, "outcome", 32'(outcome), 32'(eoc));
                check(field == efld, req, "field", 32'(field), 32'(efld));
            end
            if (poke && n == 1 && lat > 2) begin
                start = 1'b1; din = 32'h0000_0000; // R9: must be ignored
            end
        end
        prev_oc  = eoc;
        prev_fld = efld;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(busy == 1'b0 && done == 1'b0, "R11", "flags in reset",
              {30'd0, busy, done}, 32'd0);
        check(outcome == 2'b00 && field == 12'h000, "R11", "result in reset",
              {18'd0, outcome, field}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R11", "idle after reset",
              {30'd0, busy, done}, 32'd0);
        // R2 small values
        run(32'h0000_0000, "R2", 1'b0);
        run(32'h0000_007F, "R2", 1'b0);
        run(32'h0000_00FF, "R2", 1'b0);
        // R3 single-bit values
        for (int i = 0; i < 32; i++) run(32'h1 << i, "R3", 1'b0);
        // R4 smallest code
        run(32'h0000_0204, "R4", 1'b0);
        run(32'h1000_0008, "R4", 1'b0);
        // R5 rejections
        run(32'h0000_0101, "R5", 1'b0);
        run(32'h0000_0102, "R5", 1'b0);
        // R6 inverted
        run(32'hEFFF_FFF7, "R6", 1'b0);
        run(32'hFFFF_F00F, "R6", 1'b0);
        run(32'hFFFF_FFFF, "R6", 1'b0);
        // R7 pool
        run(32'hFF00_00FF, "R7", 1'b0);
        run(32'h007F_9000, "R7", 1'b0);
        // R9 start while busy is ignored
        run(32'h0000_0204, "R9", 1'b1);
        run(32'hFFFF_F00F, "R9", 1'b1);
        run(32'h007F_9000, "R9", 1'b1);
        // R1 field layout on mixed patterns
        run(32'hC000_003F, "R1", 1'b0);
        run(32'h0003_FC00, "R1", 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule